// File: doc/BRIEF.md
# EPP Cycle Timeout Controller

This block runs one enhanced-parallel-port transfer at a time toward an attached peripheral. The transfer is either an address cycle or a data cycle, in either direction. The host starts a transfer with a one-cycle start pulse. It then sees the block as busy, with its bus stalled, until the transfer ends. On the peripheral side the block drives one of two active-low strobes and watches the peripheral's wait handshake.

The wait input passes through a two-flop synchronizer. When the synchronized wait rises, the strobe is released and any read byte is captured. The transfer then finishes once wait falls again.

If wait has not risen before a window of `TIMEOUT_CYCLES` clock cycles expires, the transfer is abandoned. The strobe is released, a read returns all ones, and a sticky timeout flag is set. The flag is visible in bit 0 of the status word, and a zero there means transfers can proceed. The parameter `CLEAR_ON_WRITE` picks how software clears the flag: either by reading the status word, or by writing a 1 to bit 0. While the port is not in EPP mode, bit 0 reads as 1 and start pulses are ignored.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset the block is idle: host_busy 0, both strobes and pp_write_n high, pp_data_oe 0, and status bit 0 reads 0 in EPP mode.
- R2: A start pulse while idle and in EPP mode begins a transfer on the next clock edge, with the following pin behaviour:
  - pp_addr_stb_n goes low when host_is_addr is 1; otherwise pp_data_stb_n goes low.
  - A write drives pp_write_n low, sets pp_data_oe and puts host_wdata on pp_data_out.
  - A read keeps pp_write_n high and pp_data_oe low.
  - host_busy stays 1 until the transfer ends.
- R3: When the synchronized wait rises, the strobe is released and pp_data_in is captured. The transfer ends when the synchronized wait falls again. At that point host_done pulses for one cycle and host_busy falls, and for a read host_rdata holds the captured byte.
- R4: A strobe stays low for at most TIMEOUT_CYCLES cycles. If wait is not seen within that window, the strobe is released, host_done pulses, host_rdata is 0xFF and the timeout flag is set. A wait that arrives after the transfer ended has no effect.
- R5: The timeout flag is sticky: later transfers that succeed leave it set.
- R6: With CLEAR_ON_WRITE = 0, a status read (stat_rd) clears the flag, and a status write has no effect on it.
- R7: With CLEAR_ON_WRITE = 1, a status write with stat_wbit = 1 clears the flag. A status read, or a write with stat_wbit = 0, leaves it set.
- R8: While epp_mode is 0, status bit 0 reads 1 and start pulses are ignored.
- R9: A start pulse during a transfer is ignored, and at most one strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| epp_mode | input | 1 | Port is in EPP mode |
| host_start | input | 1 | One-cycle transfer start |
| host_is_write | input | 1 | 1 = write transfer, 0 = read |
| host_is_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| host_wdata | input | DW | Byte to write |
| host_busy | output | 1 | Transfer in progress, host bus stalled |
| host_done | output | 1 | One-cycle end-of-transfer pulse |
| host_rdata | output | DW | Read result, 0xFF after a timeout |
| stat_rd | input | 1 | Status word read strobe |
| stat_wr | input | 1 | Status word write strobe |
| stat_wbit | input | 1 | Value written to status bit 0 |
| stat_rdata | output | DW | Status word, bit 0 = timeout flag |
| pp_data_out | output | DW | Data lines driven toward the peripheral |
| pp_data_oe | output | 1 | Data line output enable |
| pp_data_in | input | DW | Data lines from the peripheral |
| pp_addr_stb_n | output | 1 | Address strobe, active low |
| pp_data_stb_n | output | 1 | Data strobe, active low |
| pp_write_n | output | 1 | Direction, low for a write |
| pp_wait | input | 1 | Peripheral wait handshake |

## Verification
The hardest case to reach from the ports is the peripheral answering too late, after the window has closed and the block is back at idle. That stray wait must not revive the transfer or cause a second done. The peripheral model reaches this case by holding wait low through a full timeout, counting the strobe-low cycles, and only then pulsing wait while the bench watches busy and both strobes. A second hard case is a start pulse that lands mid-transfer. It is raised from a parallel process while a slow peripheral holds the first transfer open, and the scoreboard fails on any done it did not expect.

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl #(
  parameter int TIMEOUT_CYCLES = 500,
  parameter bit CLEAR_ON_WRITE = 1'b0,
  parameter int DW             = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epp_mode,
  input  logic          host_start,
  input  logic          host_is_write,
  input  logic          host_is_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          stat_wbit,
  output logic [DW-1:0] stat_rdata,
  output logic [DW-1:0] pp_data_out,
  output logic          pp_data_oe,
  input  logic [DW-1:0] pp_data_in,
  output logic          pp_addr_stb_n,
  output logic          pp_data_stb_n,
  output logic          pp_write_n,
  input  logic          pp_wait
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_RELEASE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          is_addr_q, is_write_q, done_q, to_flag;
  logic          wait_m, wait_s;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          timeout_hit, flag_clr;

  assign timeout_hit = (state == S_STROBE) && !wait_s && (cnt == LAST);
  assign flag_clr    = CLEAR_ON_WRITE ? (stat_wr && stat_wbit) : stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_m <= 1'b0;
      wait_s <= 1'b0;
    end else begin
      wait_m <= pp_wait;
      wait_s <= wait_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      is_addr_q  <= 1'b0;
      is_write_q <= 1'b0;
      wdata_q    <= '0;
      rdata_q    <= '1;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (host_start && epp_mode) begin
          state      <= S_STROBE;
          cnt        <= '0;
          is_addr_q  <= host_is_addr;
          is_write_q <= host_is_write;
          wdata_q    <= host_wdata;
        end
        S_STROBE: if (wait_s) begin
          rdata_q <= pp_data_in;
          state   <= S_RELEASE;
        end else if (timeout_hit) begin
          rdata_q <= '1;
          done_q  <= 1'b1;
          state   <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_RELEASE: if (!wait_s) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_flag <= 1'b0;
    else        to_flag <= timeout_hit | (to_flag & ~flag_clr);
  end

  assign host_busy     = (state != S_IDLE);
  assign host_done     = done_q;
  assign host_rdata    = rdata_q;
  assign stat_rdata    = {{(DW-1){1'b0}}, to_flag | ~epp_mode};
  assign pp_addr_stb_n = !((state == S_STROBE) && is_addr_q);
  assign pp_data_stb_n = !((state == S_STROBE) && !is_addr_q);
  assign pp_data_oe    = host_busy && is_write_q;
  assign pp_write_n    = !pp_data_oe;
  assign pp_data_out   = wdata_q;
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
  parameter int TIMEOUT_CYCLES = 500
) (
  input logic clk,
  input logic rst_n,
  input logic epp_mode,
  input logic host_start,
  input logic host_busy,
  input logic host_done,
  input logic stat_bit0,
  input logic pp_addr_stb_n,
  input logic pp_data_stb_n,
  input logic pp_write_n,
  input logic pp_data_oe
);
  localparam int RW = $clog2(TIMEOUT_CYCLES + 2);
  logic [RW-1:0] run;
  logic          stb_on;

  assign stb_on = !pp_addr_stb_n || !pp_data_stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= '0;
    else if (stb_on) run <= run + 1'b1;
    else             run <= '0;
  end

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pp_addr_stb_n || pp_data_stb_n);
  p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_on |-> host_busy);
  p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pp_data_oe |-> !pp_write_n);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !host_busy);
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(TIMEOUT_CYCLES));
  p_nonepp_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !epp_mode |-> stat_bit0);
  p_nonepp_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && host_start && !epp_mode) |=> !host_busy);
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_start(host_start),
  .host_busy(host_busy), .host_done(host_done), .stat_bit0(stat_rdata[0]),
  .pp_addr_stb_n(pp_addr_stb_n), .pp_data_stb_n(pp_data_stb_n),
  .pp_write_n(pp_write_n), .pp_data_oe(pp_data_oe)
);

// File: tb/epp_cycle_ctrl_tb.sv
module epp_cycle_ctrl_tb;
  localparam int TO = 20;

  logic clk = 1'b0, rst_n = 1'b0, epp_mode = 1'b1;
  logic start = 1'b0, is_wr = 1'b0, is_ad = 1'b0;
  logic [7:0] wdata = '0, din = '0;
  logic busy, done, oe, astb_n, dstb_n, wr_n;
  logic [7:0] rdata, stat, dout;
  logic stat_rd = 1'b0, stat_wr = 1'b0, wbit = 1'b0, pwait = 1'b0;

  logic w_start = 1'b0, w_rd = 1'b0, w_wr = 1'b0, w_wbit = 1'b0, zero = 1'b0;
  logic w_busy, w_done, w_oe, w_astb, w_dstb, w_wrn;
  logic [7:0] w_rdata, w_stat, w_dout;

  int checks = 0, errors = 0;
  logic exp_flag = 1'b0;
  logic [9:0] q[$];

  always #2 clk = ~clk;

  epp_cycle_ctrl #(.TIMEOUT_CYCLES(TO), .CLEAR_ON_WRITE(1'b0), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_start(start),
    .host_is_write(is_wr), .host_is_addr(is_ad), .host_wdata(wdata),
    .host_busy(busy), .host_done(done), .host_rdata(rdata),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wbit(wbit), .stat_rdata(stat),
    .pp_data_out(dout), .pp_data_oe(oe), .pp_data_in(din),
    .pp_addr_stb_n(astb_n), .pp_data_stb_n(dstb_n), .pp_write_n(wr_n), .pp_wait(pwait));

  epp_cycle_ctrl #(.TIMEOUT_CYCLES(TO), .CLEAR_ON_WRITE(1'b1), .DW(8)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_start(w_start),
    .host_is_write(zero), .host_is_addr(zero), .host_wdata(din),
    .host_busy(w_busy), .host_done(w_done), .host_rdata(w_rdata),
    .stat_rd(w_rd), .stat_wr(w_wr), .stat_wbit(w_wbit), .stat_rdata(w_stat),
    .pp_data_out(w_dout), .pp_data_oe(w_oe), .pp_data_in(din),
    .pp_addr_stb_n(w_astb), .pp_data_stb_n(w_dstb), .pp_write_n(w_wrn), .pp_wait(zero));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        logic [9:0] e;
        e = q.pop_front();
        if (e[9]) check(rdata == e[7:0], "R3 R4 read data", rdata, e[7:0]);
        check(stat[0] == e[8], "R5 flag after transfer", stat[0], e[8]);
      end
    end
  end

  task automatic run_cycle(input bit wr, input bit ad, input logic [7:0] wd,
                           input int dly, input logic [7:0] pd, input bit respond);
    int n;
    @(negedge clk);
    is_wr = wr; is_ad = ad; wdata = wd; start = 1'b1;
    if (!respond) exp_flag = 1'b1;
    q.push_back({!wr, exp_flag, respond ? pd : 8'hFF});
    @(negedge clk);
    start = 1'b0;
    check((ad ? astb_n : dstb_n) == 1'b0, "R2 strobe low", ad ? astb_n : dstb_n, 0);
    check((ad ? dstb_n : astb_n) == 1'b1, "R2 other strobe high", ad ? dstb_n : astb_n, 1);
    check(busy == 1'b1, "R2 busy", busy, 1);
    if (wr) begin
      check(wr_n == 1'b0 && oe == 1'b1, "R2 write direction", {wr_n, oe}, 2'b01);
      check(dout == wd, "R2 write data", dout, wd);
    end else begin
      check(wr_n == 1'b1 && oe == 1'b0, "R2 read direction", {wr_n, oe}, 2'b10);
    end
    if (respond) begin
      repeat (dly) @(negedge clk);
      din = pd; pwait = 1'b1;
      while ((ad ? astb_n : dstb_n) == 1'b0) @(negedge clk);
      check(busy == 1'b1, "R3 busy until wait falls", busy, 1);
      pwait = 1'b0;
      while (busy) @(negedge clk);
    end else begin
      n = 1;
      forever begin
        @(negedge clk);
        if ((ad ? astb_n : dstb_n) == 1'b0) n++;
        else break;
      end
      check(n == TO, "R4 strobe window", n, TO);
      check(busy == 1'b0, "R4 idle after timeout", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check({astb_n, dstb_n, wr_n, oe} == 4'b1110, "R1 pins", {astb_n, dstb_n, wr_n, oe}, 4'b1110);
    check(stat[0] == 1'b0, "R1 flag", stat[0], 0);

    run_cycle(1'b0, 1'b0, 8'h00, 2, 8'hA5, 1'b1);
    run_cycle(1'b1, 1'b1, 8'h3C, 0, 8'h11, 1'b1);
    run_cycle(1'b0, 1'b1, 8'h00, 14, 8'h5A, 1'b1);
    run_cycle(1'b0, 1'b0, 8'h00, 0, 8'h00, 1'b0);

    pwait = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(busy == 1'b0 && astb_n && dstb_n, "R4 late wait ignored", {busy, astb_n, dstb_n}, 3'b011);
    end
    pwait = 1'b0;
    repeat (3) @(negedge clk);

    run_cycle(1'b1, 1'b0, 8'hC3, 1, 8'h00, 1'b1);
    check(stat[0] == 1'b1, "R5 sticky", stat[0], 1);

    stat_wr = 1'b1; wbit = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; wbit = 1'b0;
    @(negedge clk);
    check(stat[0] == 1'b1, "R6 write ignored", stat[0], 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; exp_flag = 1'b0;
    check(stat[0] == 1'b0, "R6 read clears", stat[0], 0);

    fork
      run_cycle(1'b0, 1'b0, 8'h00, 8, 8'h96, 1'b1);
      begin
        repeat (4) @(negedge clk);
        is_ad = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9 single done", q.size(), 0);

    epp_mode = 1'b0;
    @(negedge clk);
    check(stat[0] == 1'b1, "R8 reads high", stat[0], 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      check(busy == 1'b0 && astb_n && dstb_n, "R8 start ignored", {busy, astb_n, dstb_n}, 3'b011);
      @(negedge clk);
    end
    epp_mode = 1'b1;
    @(negedge clk);
    check(stat[0] == 1'b0, "R8 EPP flag back", stat[0], 0);

    w_start = 1'b1;
    @(negedge clk);
    w_start = 1'b0;
    while (w_busy) @(negedge clk);
    check(w_rdata == 8'hFF, "R4 timeout data", w_rdata, 8'hFF);
    check(w_stat[0] == 1'b1, "R7 flag set", w_stat[0], 1);
    w_rd = 1'b1;
    @(negedge clk);
    w_rd = 1'b0;
    @(negedge clk);
    check(w_stat[0] == 1'b1, "R7 read ignored", w_stat[0], 1);
    w_wr = 1'b1; w_wbit = 1'b0;
    @(negedge clk);
    w_wr = 1'b0;
    @(negedge clk);
    check(w_stat[0] == 1'b1, "R7 write zero ignored", w_stat[0], 1);
    w_wr = 1'b1; w_wbit = 1'b1;
    @(negedge clk);
    w_wr = 1'b0; w_wbit = 1'b0;
    check(w_stat[0] == 1'b0, "R7 write one clears", w_stat[0], 0);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R3 all transfers done", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule